// File: doc/BRIEF.md
# Used-Ring Completion Retirer with Interrupt Gate

This block retires one processed request into a split virtqueue's used ring and decides whether the driver should be interrupted. A completion brings the head descriptor index, the total response length and a count of reserved leading bytes, together with the list of writable segments that an earlier descriptor walk produced. The block walks that list one segment per cycle. It skips the reserved prefix, which can span several segments, and trims the last segment to the payload. For each span it emits a memory write request. The request names the destination address, the byte count and the offset into the response byte stream, so that a separate data mover can supply the bytes. It then writes the used element and advances its private used index.

A separate sync command publishes the private used index into the used ring header and then runs the interrupt decision. The driver's no-interrupt hint suppresses the interrupt unless notify-on-empty was negotiated and the queue is empty. Each decision either raises the queue cause bit and the interrupt line or counts a skipped interrupt. All memory traffic leaves through one valid/ready write port. Completion and sync inputs are taken only while the block is idle.

Top module: `uring_retire`

## Requirements
- R1: The payload is `cpl_total - cpl_rsvd`. When `cpl_rsvd >= cpl_total` the payload is zero: no data write is issued, but the used element is still written.
- R2: A segment whose length is not greater than the remaining skip count is passed over without a write, and its length is taken off the skip count.
- R3: The first segment not fully skipped is written from its address plus the remaining skip. Every later segment starts at offset 0. `wr_src_off` is `cpl_rsvd` plus the payload bytes already accounted for.
- R4: The last segment used is trimmed to the remaining payload. The walk stops when the payload is exhausted or the segment list (`seg_count`, at most NSEG) ends. No data write has zero length.
- R5: A segment whose `seg_buf` bit is 0 consumes skip and payload accounting exactly like a buffered one but issues no write.
- R6: After the data writes, one element write goes to `used_base + 4 + 8*(next_used mod QSIZE)` with length 8. Its data holds the head index in bits 31:0 and the full total in bits 63:32. The private used index then increments by one, modulo 2^16.
- R7: A sync issues one write of length 2 to `used_base + 2` carrying the private used index in bits 15:0. When a completion and a sync are offered in the same cycle, the completion is taken first. Neither is accepted while the block is busy.
- R8: The interrupt decision is made in the cycle the index write is accepted. It raises when `avail_no_intr` is 0, or when both `feat_notify_empty` and `queue_empty` are 1. A raise sets bit 0 of `isr` and drives `irq` high, and increments `raised_cnt`. Otherwise `skipped_cnt` increments.
- R9: While `wr_valid` is high and `wr_ready` is low, the request stays valid and its kind, address and length do not change. `wr_kind` codes: 0 data, 1 used element, 2 used index.
- R10: `isr_ack` clears `isr` and lowers `irq`. A raise in the same cycle as an ack wins, and leaves `irq` high.
- R11: After reset the block is idle and ready, `irq`, `isr` and both counters are zero, and no write is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| used_base | input | ADDR_W | Byte address of the used ring header |
| cpl_valid | input | 1 | Completion offered |
| cpl_ready | output | 1 | Completion accepted when high with cpl_valid |
| cpl_head | input | 16 | Head descriptor index of the request |
| cpl_total | input | LEN_W | Total response length in bytes |
| cpl_rsvd | input | LEN_W | Reserved leading bytes not copied |
| seg_count | input | $clog2(NSEG+1) | Number of writable segments |
| seg_addr | input | NSEG*ADDR_W | Segment addresses, segment i at bits i*ADDR_W |
| seg_len | input | NSEG*LEN_W | Segment lengths, segment i at bits i*LEN_W |
| seg_buf | input | NSEG | Segment has a data buffer attached |
| sync_valid | input | 1 | Publish-and-notify command offered |
| sync_ready | output | 1 | Sync accepted when high with sync_valid |
| avail_no_intr | input | 1 | Driver's no-interrupt hint from the available ring |
| feat_notify_empty | input | 1 | Notify-on-empty feature negotiated |
| queue_empty | input | 1 | Available ring currently empty |
| isr_ack | input | 1 | Clear interrupt status and lower the line |
| wr_valid | output | 1 | Memory write request valid |
| wr_ready | input | 1 | Memory write request accepted |
| wr_kind | output | 2 | 0 data, 1 used element, 2 used index |
| wr_addr | output | ADDR_W | Destination byte address |
| wr_len | output | LEN_W | Byte count |
| wr_src_off | output | LEN_W | Offset in the response stream (data writes) |
| wr_data | output | 64 | Inline data for element or index writes |
| irq | output | 1 | Interrupt line |
| isr | output | 8 | Interrupt status, bit 0 is the queue cause |
| raised_cnt | output | CNT_W | Interrupts raised, wrapping |
| skipped_cnt | output | CNT_W | Interrupts suppressed, wrapping |

## Verification
The interrupt status has two writers that can act in one cycle: the decision at index-write acceptance sets it, and the acknowledge clears it. The bench holds `isr_ack` high for the whole of a sync, so the ack coincides with the decision edge. It then expects the line to be high exactly when the decision raises, and low otherwise. A second same-cycle pairing, a completion and a sync offered together, is judged by the write order, where the element must precede the index write, and by the published index, which must already include the new element.

// File: rtl/uring_pkg.sv
package uring_pkg;

   typedef enum logic [1:0] {
      WK_DATA  = 2'd0,
      WK_ELEM  = 2'd1,
      WK_INDEX = 2'd2
   } wr_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WALK  = 2'd1,
      ST_ELEM  = 2'd2,
      ST_INDEX = 2'd3
   } rt_state_e;

   // used ring layout (byte offsets from the ring base)
   localparam int USED_IDX_OFS    = 2;
   localparam int USED_ELEM_OFS   = 4;
   localparam int USED_ELEM_SHIFT = 3;
   localparam int ELEM_BYTES      = 8;
   localparam int IDX_BYTES       = 2;

   localparam int ISR_QUEUE_BIT   = 0;

endpackage

// File: rtl/uring_seg_step.sv
// One step of the segment walk: skip accounting and trim of a single segment.
module uring_seg_step #(
   parameter int LEN_W = 32
) (
   input  logic [LEN_W-1:0] skip_i,
   input  logic [LEN_W-1:0] remain_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic             has_buf_i,
   output logic             whole_o,
   output logic             write_o,
   output logic [LEN_W-1:0] wlen_o,
   output logic [LEN_W-1:0] skip_nx_o,
   output logic [LEN_W-1:0] remain_nx_o
);
   logic [LEN_W-1:0] avail;

   always_comb begin
      whole_o     = (skip_i >= len_i);
      avail       = len_i - skip_i;
      wlen_o      = (avail > remain_i) ? remain_i : avail;
      skip_nx_o   = whole_o ? (skip_i - len_i) : '0;
      remain_nx_o = whole_o ? remain_i : (remain_i - wlen_o);
      write_o     = !whole_o && has_buf_i;
   end
endmodule

// File: rtl/uring_irq_gate.sv
// Interrupt decision, status bit, line and raised/skipped counters.
module uring_irq_gate #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             eval_i,
   input  logic             no_intr_i,
   input  logic             feat_empty_i,
   input  logic             q_empty_i,
   input  logic             ack_i,
   output logic             irq_o,
   output logic [7:0]       isr_o,
   output logic [CNT_W-1:0] raised_o,
   output logic [CNT_W-1:0] skipped_o
);
   import uring_pkg::*;

   logic want;
   logic raise;

   assign want  = !no_intr_i || (feat_empty_i && q_empty_i);
   assign raise = eval_i && want;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_o     <= 1'b0;
         isr_o     <= '0;
         raised_o  <= '0;
         skipped_o <= '0;
      end else begin
         if (raise) begin
            isr_o[ISR_QUEUE_BIT] <= 1'b1;
            irq_o                <= 1'b1;
            raised_o             <= raised_o + 1'b1;
         end else if (ack_i) begin
            isr_o <= '0;
            irq_o <= 1'b0;
         end
         if (eval_i && !want)
            skipped_o <= skipped_o + 1'b1;
      end
   end
endmodule

// File: rtl/uring_retire.sv
// Used-ring completion retirer: segment walk, element and index writes, interrupt gate.
module uring_retire #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 32,
   parameter int NSEG   = 4,
   parameter int QSIZE  = 8,
   parameter int CNT_W  = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         used_base,
   input  logic                      cpl_valid,
   output logic                      cpl_ready,
   input  logic [15:0]               cpl_head,
   input  logic [LEN_W-1:0]          cpl_total,
   input  logic [LEN_W-1:0]          cpl_rsvd,
   input  logic [$clog2(NSEG+1)-1:0] seg_count,
   input  logic [NSEG*ADDR_W-1:0]    seg_addr,
   input  logic [NSEG*LEN_W-1:0]     seg_len,
   input  logic [NSEG-1:0]           seg_buf,
   input  logic                      sync_valid,
   output logic                      sync_ready,
   input  logic                      avail_no_intr,
   input  logic                      feat_notify_empty,
   input  logic                      queue_empty,
   input  logic                      isr_ack,
   output logic                      wr_valid,
   input  logic                      wr_ready,
   output logic [1:0]                wr_kind,
   output logic [ADDR_W-1:0]         wr_addr,
   output logic [LEN_W-1:0]          wr_len,
   output logic [LEN_W-1:0]          wr_src_off,
   output logic [63:0]               wr_data,
   output logic                      irq,
   output logic [7:0]                isr,
   output logic [CNT_W-1:0]          raised_cnt,
   output logic [CNT_W-1:0]          skipped_cnt
);
   import uring_pkg::*;

   localparam int SEG_W   = $clog2(NSEG + 1);
   localparam bit QS_POW2 = (QSIZE & (QSIZE - 1)) == 0;

   // elaboration-time parameter checks
   if (NSEG < 1)                 begin : g_bad_nseg  $error("NSEG must be at least 1");        end
   if (QSIZE < 1 || QSIZE > 32768) begin : g_bad_qsize $error("QSIZE out of range");          end
   if (LEN_W < 4 || LEN_W > 32)  begin : g_bad_len   $error("LEN_W must be within 4..32");     end
   if (ADDR_W < 8)               begin : g_bad_addr  $error("ADDR_W too small");               end

   rt_state_e        state;
   logic [SEG_W-1:0] seg_i;
   logic [LEN_W-1:0] skip_q, remain_q, done_q, rsvd_q, total_q;
   logic [15:0]      head_q, next_used, slot;

   // unpack the segment list
   logic [ADDR_W-1:0] seg_addr_a [NSEG];
   logic [LEN_W-1:0]  seg_len_a  [NSEG];
   for (genvar g = 0; g < NSEG; g++) begin : g_unpack
      assign seg_addr_a[g] = seg_addr[g*ADDR_W +: ADDR_W];
      assign seg_len_a[g]  = seg_len[g*LEN_W +: LEN_W];
   end

   // slot = next_used mod QSIZE; mask when the ring size is a power of two
   if (QS_POW2) begin : g_slot_mask
      assign slot = next_used & 16'(QSIZE - 1);
   end else begin : g_slot_mod
      assign slot = next_used % 16'(QSIZE);
   end

   logic              walk_end;
   logic [SEG_W-1:0]  sel;
   logic [ADDR_W-1:0] cur_addr;
   logic [LEN_W-1:0]  cur_len;
   logic              cur_buf;

   assign walk_end = (seg_i >= seg_count) || (seg_i >= SEG_W'(NSEG)) || (remain_q == '0);
   assign sel      = (seg_i < SEG_W'(NSEG)) ? seg_i : '0;
   assign cur_addr = seg_addr_a[sel];
   assign cur_len  = seg_len_a[sel];
   assign cur_buf  = seg_buf[sel];

   logic             st_whole, st_write;
   logic [LEN_W-1:0] st_wlen, st_skip_nx, st_remain_nx;

   uring_seg_step #(.LEN_W(LEN_W)) u_step (
      .skip_i      (skip_q),
      .remain_i    (remain_q),
      .len_i       (cur_len),
      .has_buf_i   (cur_buf),
      .whole_o     (st_whole),
      .write_o     (st_write),
      .wlen_o      (st_wlen),
      .skip_nx_o   (st_skip_nx),
      .remain_nx_o (st_remain_nx)
   );

   assign cpl_ready  = (state == ST_IDLE);
   assign sync_ready = (state == ST_IDLE) && !cpl_valid;

   // write request port
   always_comb begin
      wr_valid   = 1'b0;
      wr_kind    = WK_DATA;
      wr_addr    = '0;
      wr_len     = '0;
      wr_src_off = '0;
      wr_data    = '0;
      case (state)
         ST_WALK: begin
            wr_valid   = !walk_end && st_write;
            wr_addr    = cur_addr + ADDR_W'(skip_q);
            wr_len     = st_wlen;
            wr_src_off = rsvd_q + done_q;
         end
         ST_ELEM: begin
            wr_valid = 1'b1;
            wr_kind  = WK_ELEM;
            wr_addr  = used_base + ADDR_W'(USED_ELEM_OFS) + (ADDR_W'(slot) << USED_ELEM_SHIFT);
            wr_len   = LEN_W'(ELEM_BYTES);
            wr_data  = {32'(total_q), 16'h0, head_q};
         end
         ST_INDEX: begin
            wr_valid = 1'b1;
            wr_kind  = WK_INDEX;
            wr_addr  = used_base + ADDR_W'(USED_IDX_OFS);
            wr_len   = LEN_W'(IDX_BYTES);
            wr_data  = {48'h0, next_used};
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         seg_i     <= '0;
         skip_q    <= '0;
         remain_q  <= '0;
         done_q    <= '0;
         rsvd_q    <= '0;
         total_q   <= '0;
         head_q    <= '0;
         next_used <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (cpl_valid) begin
                  seg_i    <= '0;
                  skip_q   <= cpl_rsvd;
                  remain_q <= (cpl_total > cpl_rsvd) ? (cpl_total - cpl_rsvd) : '0;
                  done_q   <= '0;
                  rsvd_q   <= cpl_rsvd;
                  total_q  <= cpl_total;
                  head_q   <= cpl_head;
                  state    <= ST_WALK;
               end else if (sync_valid) begin
                  state <= ST_INDEX;
               end
            end
            ST_WALK: begin
               if (walk_end) begin
                  state <= ST_ELEM;
               end else if (!st_write || wr_ready) begin
                  skip_q   <= st_skip_nx;
                  remain_q <= st_remain_nx;
                  if (!st_whole) done_q <= done_q + st_wlen;
                  seg_i    <= seg_i + 1'b1;
               end
            end
            ST_ELEM: begin
               if (wr_ready) begin
                  next_used <= next_used + 16'd1;
                  state     <= ST_IDLE;
               end
            end
            ST_INDEX: begin
               if (wr_ready) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   logic eval;
   assign eval = (state == ST_INDEX) && wr_ready;

   uring_irq_gate #(.CNT_W(CNT_W)) u_irq (
      .clk          (clk),
      .rst_n        (rst_n),
      .eval_i       (eval),
      .no_intr_i    (avail_no_intr),
      .feat_empty_i (feat_notify_empty),
      .q_empty_i    (queue_empty),
      .ack_i        (isr_ack),
      .irq_o        (irq),
      .isr_o        (isr),
      .raised_o     (raised_cnt),
      .skipped_o    (skipped_cnt)
   );
endmodule

// File: rtl/uring_retire_chk.sv
// Port-level properties of the retirer, bound to every instance.
module uring_retire_chk #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 32,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpl_ready,
   input logic              sync_ready,
   input logic              isr_ack,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic [1:0]        wr_kind,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [LEN_W-1:0]  wr_len,
   input logic              irq,
   input logic [7:0]        isr,
   input logic [CNT_W-1:0]  raised_cnt,
   input logic [CNT_W-1:0]  skipped_cnt
);
   logic idx_hs;
   assign idx_hs = wr_valid && wr_ready && (wr_kind == 2'd2);

   // R9: request held under backpressure
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_kind) && $stable(wr_addr) && $stable(wr_len));

   // R4: no zero-length data write
   a_r4_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && (wr_kind == 2'd0) |-> wr_len != '0);

   // R7: nothing accepted while a write is pending
   a_r7_busy: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> !cpl_ready && !sync_ready);

   // R8: the line only rises right after an index write was accepted
   a_r8_rise_after_index: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(idx_hs));

   // R8: each counter moves only on a decision
   a_r8_count_source: assert property (@(posedge clk) disable iff (!rst_n)
      (raised_cnt != $past(raised_cnt)) || (skipped_cnt != $past(skipped_cnt)) |-> $past(idx_hs));

   // R8: line and queue cause bit agree
   a_r8_line_matches: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> isr[0]);

   // R10: an ack with no decision clears status and line
   a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      isr_ack && !idx_hs |=> !irq && (isr == 8'h00));
endmodule

bind uring_retire uring_retire_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cpl_ready   (cpl_ready),
   .sync_ready  (sync_ready),
   .isr_ack     (isr_ack),
   .wr_valid    (wr_valid),
   .wr_ready    (wr_ready),
   .wr_kind     (wr_kind),
   .wr_addr     (wr_addr),
   .wr_len      (wr_len),
   .irq         (irq),
   .isr         (isr),
   .raised_cnt  (raised_cnt),
   .skipped_cnt (skipped_cnt)
);

// File: tb/sim_uring_retire.sv
module sim_uring_retire;
   localparam int ADDR_W = 32;
   localparam int LEN_W  = 16;
   localparam int NSEG   = 4;
   localparam int QSIZE  = 4;
   localparam int CNT_W  = 8;
   localparam int SEG_W  = $clog2(NSEG + 1);
   localparam logic [31:0] BASE = 32'h0000_8000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic              cpl_valid = 0, cpl_ready;
   logic [15:0]       cpl_head = 0;
   logic [LEN_W-1:0]  cpl_total = 0, cpl_rsvd = 0;
   logic [SEG_W-1:0]  seg_count = 0;
   logic [NSEG*ADDR_W-1:0] seg_addr;
   logic [NSEG*LEN_W-1:0]  seg_len;
   logic [NSEG-1:0]   seg_buf = '1;
   logic              sync_valid = 0, sync_ready;
   logic              avail_no_intr = 0, feat_notify_empty = 0, queue_empty = 0, isr_ack = 0;
   logic              wr_valid, wr_ready = 1;
   logic [1:0]        wr_kind;
   logic [ADDR_W-1:0] wr_addr;
   logic [LEN_W-1:0]  wr_len, wr_src_off;
   logic [63:0]       wr_data;
   logic              irq;
   logic [7:0]        isr;
   logic [CNT_W-1:0]  raised_cnt, skipped_cnt;

   uring_retire #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .NSEG(NSEG), .QSIZE(QSIZE), .CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .used_base(BASE),
      .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_head(cpl_head),
      .cpl_total(cpl_total), .cpl_rsvd(cpl_rsvd),
      .seg_count(seg_count), .seg_addr(seg_addr), .seg_len(seg_len), .seg_buf(seg_buf),
      .sync_valid(sync_valid), .sync_ready(sync_ready),
      .avail_no_intr(avail_no_intr), .feat_notify_empty(feat_notify_empty),
      .queue_empty(queue_empty), .isr_ack(isr_ack),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_kind(wr_kind), .wr_addr(wr_addr),
      .wr_len(wr_len), .wr_src_off(wr_src_off), .wr_data(wr_data),
      .irq(irq), .isr(isr), .raised_cnt(raised_cnt), .skipped_cnt(skipped_cnt)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // fixed segment table: lengths 3, 0, 5, 4
   int s_len [NSEG] = '{3, 0, 5, 4};
   initial begin
      for (int i = 0; i < NSEG; i++) begin
         seg_addr[i*ADDR_W +: ADDR_W] = 32'h1000 * (i + 1);
         seg_len[i*LEN_W +: LEN_W]    = LEN_W'(s_len[i]);
      end
   end

   // expected write list
   int          exp_kind [16];
   logic [31:0] exp_addr [16];
   int          exp_len  [16];
   int          exp_off  [16];
   logic [63:0] exp_data [16];
   string       exp_tag  [16];
   int exp_n = 0, cap_n = 0;
   int m_used = 0, m_raised = 0, m_skipped = 0, m_irq = 0;

   task automatic push(int k, logic [31:0] a, int l, int o, logic [63:0] d, string t);
      exp_kind[exp_n] = k; exp_addr[exp_n] = a; exp_len[exp_n] = l;
      exp_off[exp_n] = o;  exp_data[exp_n] = d; exp_tag[exp_n] = t;
      exp_n++;
   endtask

   task automatic check(bit ok, string tag, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // backpressure pattern and write capture
   bit stall_mode = 0;
   logic [7:0] lfsr = 8'h5a;
   always @(negedge clk) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      wr_ready = stall_mode ? lfsr[0] : 1'b1;
      #1;
      if (rst_n && wr_valid && wr_ready) begin
         if (cap_n >= exp_n) begin
            check(0, "R4", "unexpected write addr", wr_addr, 0);
         end else begin
            check(int'(wr_kind) == exp_kind[cap_n], exp_tag[cap_n], "kind", wr_kind, exp_kind[cap_n]);
            check(wr_addr == exp_addr[cap_n], exp_tag[cap_n], "addr", wr_addr, exp_addr[cap_n]);
            check(int'(wr_len) == exp_len[cap_n], exp_tag[cap_n], "len", wr_len, exp_len[cap_n]);
            if (exp_kind[cap_n] == 0)
               check(int'(wr_src_off) == exp_off[cap_n], exp_tag[cap_n], "src_off", wr_src_off, exp_off[cap_n]);
            else
               check(wr_data == exp_data[cap_n], exp_tag[cap_n], "data", wr_data, exp_data[cap_n]);
         end
         cap_n++;
      end
   end

   // model of one completion (R1..R6)
   task automatic model_cpl(int total, int rsvd, int head, int cnt, logic [NSEG-1:0] bufs);
      int skip = rsvd;
      int remain = (total > rsvd) ? total - rsvd : 0;
      int used = 0;
      for (int i = 0; i < cnt; i++) begin
         int w;
         if (remain == 0) break;
         if (skip >= s_len[i]) begin
            skip -= s_len[i];
            continue;
         end
         w = s_len[i] - skip;
         if (w > remain) w = remain;
         if (bufs[i])
            push(0, 32'(32'h1000 * (i + 1) + skip), w, rsvd + used, 64'h0, "R3");
         used += w;
         remain -= w;
         skip = 0;
      end
      push(1, BASE + 4 + 8 * (m_used % QSIZE), 8, 0, {32'(total), 16'h0, 16'(head)}, "R6");
      m_used = (m_used + 1) & 16'hffff;
   endtask

   task automatic wait_idle();
      while (!cpl_ready) @(negedge clk);
   endtask

   task automatic run_cpl(int total, int rsvd, int head, int cnt, logic [NSEG-1:0] bufs, string tag);
      @(negedge clk);
      exp_n = 0; cap_n = 0;
      model_cpl(total, rsvd, head, cnt, bufs);
      cpl_total = LEN_W'(total); cpl_rsvd = LEN_W'(rsvd); cpl_head = 16'(head);
      seg_count = SEG_W'(cnt); seg_buf = bufs; cpl_valid = 1;
      while (!cpl_ready) @(negedge clk);
      @(negedge clk);
      cpl_valid = 0;
      wait_idle();
      @(negedge clk);
      // R2 R4 R5: number of writes issued for the completion
      check(cap_n == exp_n, tag, "write count", cap_n, exp_n);
   endtask

   task automatic run_sync(bit ni, bit fe, bit em, bit ack);
      bit raise = !ni || (fe && em);
      @(negedge clk);
      exp_n = 0; cap_n = 0;
      push(2, BASE + 2, 2, 0, 64'(m_used), "R7");
      avail_no_intr = ni; feat_notify_empty = fe; queue_empty = em; isr_ack = ack;
      sync_valid = 1;
      while (!sync_ready) @(negedge clk);
      @(negedge clk);
      sync_valid = 0;
      wait_idle();
      isr_ack = 0;
      if (raise) begin m_raised++; m_irq = 1; end
      else begin m_skipped++; if (ack) m_irq = 0; end
      @(negedge clk);
      check(cap_n == exp_n, "R7", "index write count", cap_n, exp_n);
      check(irq == m_irq[0], ack ? "R10" : "R8", "irq", irq, m_irq);
      check(isr == 8'(m_irq), "R8", "isr", isr, m_irq);
      check(raised_cnt == CNT_W'(m_raised), "R8", "raised_cnt", raised_cnt, m_raised);
      check(skipped_cnt == CNT_W'(m_skipped), "R8", "skipped_cnt", skipped_cnt, m_skipped);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      check(cpl_ready == 1, "R11", "cpl_ready", cpl_ready, 1);
      check(wr_valid == 0, "R11", "wr_valid", wr_valid, 0);
      check(irq == 0 && isr == 0, "R11", "irq/isr", {irq, isr}, 0);
      check(raised_cnt == 0 && skipped_cnt == 0, "R11", "counters", {raised_cnt, skipped_cnt}, 0);
      rst_n = 1;
      @(negedge clk);
      check(cpl_ready == 1 && wr_valid == 0 && irq == 0, "R11", "after release", {cpl_ready, wr_valid, irq}, 3'b100);

      // sweep: total 1..14, reserved 0..total (R1 at rsvd == total), two buffer patterns (R5)
      for (int b = 0; b < 2; b++) begin
         for (int t = 1; t <= 14; t++) begin
            for (int r = 0; r <= t; r++) begin
               stall_mode = ((t + r) % 2) == 1;
               run_cpl(t, r, t * 37 + r, NSEG, b ? 4'b1011 : 4'b1111,
                       (r == t) ? "R1" : (b ? "R5" : "R2"));
            end
         end
      end
      // short segment lists (R4 stop at list end)
      for (int c = 0; c <= NSEG; c++) begin
         stall_mode = c[0];
         run_cpl(12, 1, 100 + c, c, 4'b1111, "R4");
      end
      // reserved larger than total: zero payload (R1)
      run_cpl(3, 7, 7, NSEG, 4'b1111, "R1");

      // interrupt decisions, all input combinations (R8), with and without ack (R10)
      for (int a = 0; a < 2; a++) begin
         for (int k = 0; k < 8; k++) begin
            stall_mode = k[0];
            run_sync(k[2], k[1], k[0], a[0]);
         end
      end

      // lone ack lowers the line (R10)
      run_sync(0, 0, 0, 0);
      @(negedge clk); isr_ack = 1;
      @(negedge clk); isr_ack = 0; m_irq = 0;
      check(irq == 0 && isr == 0, "R10", "ack clear", {irq, isr}, 0);

      // completion and sync offered together: element first, then index with new count (R7)
      stall_mode = 0;
      @(negedge clk);
      exp_n = 0; cap_n = 0;
      model_cpl(5, 0, 9, 0, 4'b1111);
      push(2, BASE + 2, 2, 0, 64'(m_used), "R7");
      cpl_total = 5; cpl_rsvd = 0; cpl_head = 9; seg_count = 0;
      avail_no_intr = 1; feat_notify_empty = 0; queue_empty = 0;
      cpl_valid = 1; sync_valid = 1;
      while (!cpl_ready) @(negedge clk);
      @(negedge clk);
      cpl_valid = 0;
      while (!sync_ready) @(negedge clk);
      @(negedge clk);
      sync_valid = 0;
      wait_idle();
      @(negedge clk);
      m_skipped++;
      check(cap_n == exp_n, "R7", "combined write count", cap_n, exp_n);
      check(skipped_cnt == CNT_W'(m_skipped), "R8", "skipped after combined", skipped_cnt, m_skipped);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule